// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt Request

This block is a 32-bit down-counter for a processor's local interrupt logic. Software programs it through a small register port. The register set has four entries: a start value, a read-only live count, a prescaler selection and an interrupt entry. The interrupt entry holds the vector, a mask bit, a mode bit and a read-only pending flag.

An external tick input is divided by a programmable ratio between 1 and 128. The count steps down once per divided tick. When the count goes from one to zero, the block raises an interrupt request that carries the programmed vector, unless the entry is masked. The request stays up until the interrupt logic pulses the accept input. In one-shot mode the count then rests at zero. In periodic mode the count reloads the start value on the following divided tick and counts again.

Register addresses are 0 for the start value, 1 for the live count, 2 for the prescaler code and 3 for the interrupt entry. Writes take effect at the clock edge. Reads are combinational from the read address.

Top module: `cdt_timer`

## Requirements
- R1: After a synchronous active-low reset, the start value reads 0, the live count reads 0 and the prescaler code reads 0. The interrupt entry reads 0x0001_0000 (masked, one-shot, vector 0), and irq_req is low.
- R2: A write of a nonzero value to address 0 loads the live count with that value in the same edge, clears the prescaler phase and starts counting. A write of zero leaves the live count at 0, and the timer then neither counts, reloads nor raises a request, in either mode.
- R3: The live count drops by exactly one per divided tick; cycles without tick_in change nothing. The ratio is chosen by code bits {3,1,0} and bit 2 has no effect. Codes 000, 001, 010 and 011 give 2, 4, 8 and 16. Codes 100, 101 and 110 give 32, 64 and 128. Code 111 gives 1. The first decrement after a start-value write comes on the Nth tick, where N is the ratio.
- R4: In one-shot mode (entry bit 17 = 0), the live count stays at 0 after it reaches 0.
- R5: In periodic mode (entry bit 17 = 1), the divided tick after the count reaches 0 reloads the start value, and counting repeats with further expiries.
- R6: On the tick that moves the count from 1 to 0 with the entry unmasked (bit 16 = 0), irq_req goes high after that edge. irq_vector shows entry bits 7:0, and entry bit 12 reads 1.
- R7: With the mask bit (entry bit 16) set, an expiry leaves irq_req low and entry bit 12 at 0.
- R8: A one-cycle pulse on irq_accept clears irq_req and entry bit 12. An expiry in the same cycle as an accept leaves the request set.
- R9: Writes to address 1 change neither the live count nor the start value. Bit 12 of a write to the entry is ignored.
- R10: A start value of 0xFFFF_FFFF loads and reads back in full, and it decrements to 0xFFFF_FFFE on the next divided tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| tick_in | input | 1 | Undivided time-base pulse |
| irq_accept | input | 1 | Pulse that retires the pending request |
| irq_req | output | 1 | Interrupt request, held until accepted |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
The count path is driven with back-to-back ticks, with sparse ticks separated by idle cycles, and with several prescaler codes. These runs separate a decrement per raw tick from a decrement per divided tick. They also show whether code bit 2 is really ignored and whether the divide-by-1 code is special-cased. The mode bit is exercised in both settings across several expiries. This separates holding at zero from reloading, and it shows whether a reload is taken one tick late or early. The request path is exercised masked, unmasked and with accept colliding with expiry. Together these pin down the priority between setting and clearing the pending flag.

// File: rtl/cdt_pkg.sv
// Shared definitions for the countdown timer: register selectors, entry
// layout and the prescaler code decoder.
package cdt_pkg;

    localparam int ADDR_W       = 2;
    localparam int VEC_W        = 8;
    localparam int SHIFT_W      = 3;   // log2 of the largest ratio exponent
    localparam int MAX_SHIFT    = 7;   // largest ratio is 2**7
    localparam int BIT_PEND     = 12;
    localparam int BIT_MASK     = 16;
    localparam int BIT_PERIODIC = 17;
    localparam int CODE_W       = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_START = 2'd0,
        SEL_LIVE  = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_ENTRY = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_t;

    // Map a prescaler code onto a power-of-two exponent; bit 2 is unused.
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
        logic [SHIFT_W-1:0] idx;
        idx = {code[3], code[1], code[0]};
        if (idx == 3'b111)
            return '0;
        else
            return idx + 3'd1;
    endfunction

endpackage

// File: rtl/cdt_regs.sv
// Register set of the countdown timer.
// Holds the start value, the prescaler code and the interrupt entry, flags a
// start-value write, and returns read data from a combinational mux.
// Assumes a single write port and writes that take effect at the clock edge.
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [CNT_W-1:0]    live_cnt,
    input  logic                pending,
    output logic [CNT_W-1:0]    rd_data,
    output logic [CNT_W-1:0]    start_q,
    output logic [CODE_W-1:0]   code_q,
    output entry_t              entry_q,
    output logic                load,
    output logic [CNT_W-1:0]    load_val
);

    reg_sel_e wsel, rsel;

    assign wsel     = reg_sel_e'(wr_addr);
    assign rsel     = reg_sel_e'(rd_addr);
    assign load     = wr_en && (wsel == SEL_START);
    assign load_val = wr_data;

    // Capture software writes; the live-count address has no storage here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q         <= '0;
            code_q          <= '0;
            entry_q.vector  <= '0;
            entry_q.mask    <= 1'b1;
            entry_q.periodic<= 1'b0;
        end else if (wr_en) begin
            case (wsel)
                SEL_START: start_q <= wr_data;
                SEL_DIV:   code_q  <= wr_data[CODE_W-1:0];
                SEL_ENTRY: begin
                    entry_q.vector   <= wr_data[VEC_W-1:0];
                    entry_q.mask     <= wr_data[BIT_MASK];
                    entry_q.periodic <= wr_data[BIT_PERIODIC];
                end
                default: ;
            endcase
        end
    end

    // Assemble read data for the selected register.
    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_START: rd_data = start_q;
            SEL_LIVE:  rd_data = live_cnt;
            SEL_DIV:   rd_data[CODE_W-1:0] = code_q;
            SEL_ENTRY: begin
                rd_data[VEC_W-1:0]   = entry_q.vector;
                rd_data[BIT_PEND]    = pending;
                rd_data[BIT_MASK]    = entry_q.mask;
                rd_data[BIT_PERIODIC]= entry_q.periodic;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cdt_prescale.sv
// Power-of-two prescaler for the time-base pulse.
// Counts tick_in pulses and emits one divided pulse per 2**shift pulses, in
// the same cycle as the terminal raw tick. clear restarts the phase.
// Assumes shift does not exceed MAX_SHIFT.
module cdt_prescale
    import cdt_pkg::*;
#(
    parameter int PHASE_W = MAX_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               tick_in,
    input  logic [SHIFT_W-1:0] shift,
    output logic               ptick
);

    localparam int SPAN_W = PHASE_W + 1;

    logic [PHASE_W-1:0] phase_q;
    logic [SPAN_W-1:0]  span;
    logic [PHASE_W-1:0] last;

    assign span  = {{(SPAN_W-1){1'b0}}, 1'b1} << shift;
    assign last  = PHASE_W'(span - {{(SPAN_W-1){1'b0}}, 1'b1});
    assign ptick = tick_in && (phase_q == last);

    // Advance the phase on each raw tick and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            phase_q <= '0;
        else if (tick_in)
            phase_q <= ptick ? '0 : phase_q + 1'b1;
    end

endmodule

// File: rtl/cdt_counter.sv
// Down-counter and request flag of the countdown timer.
// Loads on a start-value write, steps on divided ticks, stops or reloads at
// zero by mode, and keeps a pending flag that accept clears.
// Assumes load and ptick may coincide; load wins.
module cdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] start_val,
    input  logic             ptick,
    input  logic             periodic,
    input  logic             mask,
    input  logic             accept,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pending_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic running_q;

    assign expire = ptick && running_q && !load && (cnt_q == ONE);

    // Load, step, reload or stop the live count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else if (load) begin
            cnt_q     <= load_val;
            running_q <= |load_val;
        end else if (ptick && running_q) begin
            if (cnt_q == '0) begin
                if (periodic)
                    cnt_q <= start_val;
                else
                    running_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - ONE;
                if (cnt_q == ONE && !periodic)
                    running_q <= 1'b0;
            end
        end
    end

    // Set the request on an unmasked expiry; accept clears it, expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (expire && !mask)
            pending_q <= 1'b1;
        else if (accept)
            pending_q <= 1'b0;
    end

endmodule

// File: rtl/cdt_timer.sv
// Top of the programmable countdown timer.
// Connects the register set, the prescaler and the down-counter, and drives
// the interrupt request with the programmed vector.
// Assumes irq_accept is a single-cycle pulse from the interrupt logic.
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [CNT_W-1:0]     rd_data,
    input  logic                 tick_in,
    input  logic                 irq_accept,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vector
);

    logic [CNT_W-1:0]  start_q;
    logic [CNT_W-1:0]  cur_q;
    logic [CNT_W-1:0]  load_val;
    logic [CODE_W-1:0] code_q;
    entry_t            entry_q;
    logic              load;
    logic              ptick;
    logic              expire;
    logic              pend_q;
    logic              ent_mask;
    logic              ent_periodic;

    assign ent_mask     = entry_q.mask;
    assign ent_periodic = entry_q.periodic;
    assign irq_req      = pend_q;
    assign irq_vector   = entry_q.vector;

    cdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .live_cnt (cur_q),
        .pending  (pend_q),
        .rd_data  (rd_data),
        .start_q  (start_q),
        .code_q   (code_q),
        .entry_q  (entry_q),
        .load     (load),
        .load_val (load_val)
    );

    cdt_prescale #(.PHASE_W(MAX_SHIFT)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .tick_in (tick_in),
        .shift   (code_to_shift(code_q)),
        .ptick   (ptick)
    );

    cdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .start_val (start_q),
        .ptick     (ptick),
        .periodic  (ent_periodic),
        .mask      (ent_mask),
        .accept    (irq_accept),
        .cnt_q     (cur_q),
        .pending_q (pend_q),
        .expire    (expire)
    );

endmodule

// File: rtl/cdt_timer_chk.sv
// Temporal checks for the countdown timer, bound to its top.
// Assumes the bound signals are the top's live count, entry bits and
// internal divided-tick, load and expiry strobes.
module cdt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             irq_accept,
    input logic             irq_req,
    input logic [CNT_W-1:0] cur,
    input logic             msk,
    input logic             periodic,
    input logic             ptick,
    input logic             load,
    input logic             expire
);

    // R1: reset leaves no request and a zero count.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!irq_req && cur == '0));

    // R3: a divided tick on a count above one steps it down by one.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptick && !load && cur > CNT_W'(1)) |=> cur == CNT_W'($past(cur) - CNT_W'(1)));

    // R4: one-shot count rests at zero.
    a_r4_oneshot_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == '0 && !periodic && !load) |=> cur == '0);

    // R6: a new request follows a one-to-zero step.
    a_r6_rise_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(cur) == CNT_W'(1) && cur == '0));

    // R7: a masked entry never starts a request.
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(msk));

    // R8: accept without a colliding expiry retires the request.
    a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && !expire) |=> !irq_req);

    // R9: a write to the live-count address alone does not move the count.
    a_r9_live_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && !ptick) |=> $stable(cur));

endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .irq_accept (irq_accept),
    .irq_req    (irq_req),
    .cur        (cur_q),
    .msk        (ent_mask),
    .periodic   (ent_periodic),
    .ptick      (ptick),
    .load       (load),
    .expire     (expire)
);

// File: tb/test_cdt_timer.sv
// Scoreboard bench: the driver queues expected values, the monitor compares.
module test_cdt_timer;

    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_VEC = 2;

    typedef struct {
        string       req;
        int          kind;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tick_in = 1'b0;
    logic        irq_accept = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vector;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    always #2.5 clk = ~clk;

    cdt_timer i_cdt_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .tick_in    (tick_in),
        .irq_accept (irq_accept),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    // Monitor: pop queued expectations and compare away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_IRQ:   act = {31'd0, irq_req};
                    K_VEC:   act = {24'd0, irq_vector};
                    default: act = rd_data;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_in = 1'b1;
            cyc();
        end
        tick_in = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic accept();
        irq_accept = 1'b1;
        cyc();
        irq_accept = 1'b0;
    endtask

    task automatic expect_val(input string req, input int kind,
                              input logic [1:0] a, input logic [31:0] e);
        item_t it;
        rd_addr = a;
        it.req = req; it.kind = kind; it.exp = e;
        q.push_back(it);
        @(negedge clk);
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // Driver: stimulus and expected values derived from the requirements.
    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_val("R1 start", K_RD, 2'd0, 32'h0);
        expect_val("R1 live", K_RD, 2'd1, 32'h0);
        expect_val("R1 code", K_RD, 2'd2, 32'h0);
        expect_val("R1 entry", K_RD, 2'd3, 32'h0001_0000);
        expect_val("R1 irq", K_IRQ, 2'd0, 32'h0);

        // One-shot, divide by 1
        wr(2'd3, 32'h0000_0041);
        wr(2'd2, 32'h0000_000B);
        wr(2'd0, 32'd3);
        expect_val("R2 load", K_RD, 2'd1, 32'd3);
        tick(1);
        expect_val("R3 step", K_RD, 2'd1, 32'd2);
        idle(4);
        expect_val("R3 no tick no change", K_RD, 2'd1, 32'd2);
        tick(1);
        expect_val("R6 not yet", K_IRQ, 2'd0, 32'h0);
        tick(1);
        expect_val("R6 irq", K_IRQ, 2'd0, 32'h1);
        expect_val("R6 vector", K_VEC, 2'd0, 32'h41);
        expect_val("R6 pend bit", K_RD, 2'd3, 32'h0000_1041);
        tick(3);
        expect_val("R4 hold", K_RD, 2'd1, 32'h0);
        accept();
        expect_val("R8 accept", K_IRQ, 2'd0, 32'h0);
        expect_val("R8 pend bit", K_RD, 2'd3, 32'h0000_0041);

        // Periodic
        wr(2'd3, 32'h0002_0022);
        wr(2'd0, 32'd2);
        tick(2);
        expect_val("R5 first expiry", K_IRQ, 2'd0, 32'h1);
        tick(1);
        expect_val("R5 reload", K_RD, 2'd1, 32'd2);
        accept();
        tick(2);
        expect_val("R5 second expiry", K_IRQ, 2'd0, 32'h1);
        tick(2);
        expect_val("R5 reload again", K_RD, 2'd1, 32'd1);
        tick_in = 1'b1; irq_accept = 1'b1;
        cyc();
        tick_in = 1'b0; irq_accept = 1'b0;
        expect_val("R8 expiry beats accept", K_IRQ, 2'd0, 32'h1);
        accept();
        expect_val("R8 cleared", K_IRQ, 2'd0, 32'h0);

        // Masked
        wr(2'd3, 32'h0001_0022);
        wr(2'd0, 32'd1);
        tick(1);
        expect_val("R7 count reached zero", K_RD, 2'd1, 32'h0);
        expect_val("R7 no irq", K_IRQ, 2'd0, 32'h0);
        expect_val("R7 entry", K_RD, 2'd3, 32'h0001_0022);

        // Zero stops
        wr(2'd3, 32'h0002_0022);
        wr(2'd0, 32'd4);
        tick(1);
        expect_val("R2 running", K_RD, 2'd1, 32'd3);
        wr(2'd0, 32'd0);
        expect_val("R2 zero load", K_RD, 2'd1, 32'h0);
        tick(3);
        expect_val("R2 stopped", K_RD, 2'd1, 32'h0);
        expect_val("R2 no irq", K_IRQ, 2'd0, 32'h0);

        // Ignored writes
        wr(2'd0, 32'd9);
        wr(2'd1, 32'h0000_1234);
        expect_val("R9 live kept", K_RD, 2'd1, 32'd9);
        expect_val("R9 start kept", K_RD, 2'd0, 32'd9);
        wr(2'd3, 32'h0000_1055);
        expect_val("R9 pend write ignored", K_RD, 2'd3, 32'h0000_0055);
        expect_val("R9 irq low", K_IRQ, 2'd0, 32'h0);

        // Prescaler codes
        wr(2'd2, 32'h1);
        wr(2'd0, 32'd100);
        tick(3);
        expect_val("R3 div4 wait", K_RD, 2'd1, 32'd100);
        tick(1);
        expect_val("R3 div4 step", K_RD, 2'd1, 32'd99);
        wr(2'd2, 32'h5);
        wr(2'd0, 32'd100);
        tick(3);
        expect_val("R3 bit2 ignored wait", K_RD, 2'd1, 32'd100);
        tick(1);
        expect_val("R3 bit2 ignored step", K_RD, 2'd1, 32'd99);
        expect_val("R3 code readback", K_RD, 2'd2, 32'h5);
        wr(2'd2, 32'hA);
        wr(2'd0, 32'd50);
        tick(127);
        expect_val("R3 div128 wait", K_RD, 2'd1, 32'd50);
        tick(1);
        expect_val("R3 div128 step", K_RD, 2'd1, 32'd49);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'd10);
        tick(1);
        idle(2);
        expect_val("R3 div2 wait", K_RD, 2'd1, 32'd10);
        tick(1);
        expect_val("R3 div2 step", K_RD, 2'd1, 32'd9);

        // Largest count
        wr(2'd2, 32'hB);
        wr(2'd0, 32'hFFFF_FFFF);
        expect_val("R10 load max", K_RD, 2'd1, 32'hFFFF_FFFF);
        expect_val("R10 start max", K_RD, 2'd0, 32'hFFFF_FFFF);
        tick(1);
        expect_val("R10 step", K_RD, 2'd1, 32'hFFFF_FFFE);

        done = 1'b1;
        @(negedge clk);
        #3;
        summary();
        $finish;
    end

endmodule